// File: doc/BRIEF.md
# Serial GPIO Input Interrupt Controller

This block raises interrupts from input pins that a separate serial shifter captures. The shifter delivers one snapshot of every input pin per scan. Pins are addressed by a bit index `b` (0 to NBITS-1) and a port `p` (0 to NPORTS-1). A snapshot arrives on a valid/ready stream. The block never applies back-pressure: `scan_ready` is high at all times, and a snapshot is taken in every cycle where `scan_valid` is high.

Each pin has its own trigger setting. The options are active-level, either edge, falling edge or rising edge. For level triggering the pin also has a polarity. Each pin also has an enable and a sticky pending flag. Software reaches these through a simple word-wide register port. Writes land on the clock edge and reads are combinational. Every register holds one word per bit index, and port `p` sits at bit position `p` of that word.

A masked identity view tells software which enabled pins are pending, so a handler can scan bit indices 0 upward. A global enable gates the single combined interrupt line.

Top module: `sgi_ctrl`

## Requirements
- R1: Register word addresses (6-bit, word index `b` added to the base): global config 0x00, enable 0x04+b, trigger-low 0x08+b, trigger-high 0x0C+b, polarity 0x10+b, acknowledge 0x14+b, identity 0x18+b. Config, enable, trigger and polarity read back what was written. Acknowledge reads as zero.
- R2: A pin's trigger type is {trigger-high[b][p], trigger-low[b][p]}, encoded as 0 level, 1 both edges, 2 falling, 3 rising.
- R3: Polarity bit 0 means a level trigger is active while the pin is 1. Polarity bit 1 means it is active while the pin is 0. Polarity has no effect on edge types.
- R4: An edge is the difference between a pin's value in the accepted snapshot and its value in the previous accepted snapshot. The first snapshot after reset produces no edge. A level trigger sets pending on every snapshot in which the pin is at its active level.
- R5: Pending is sticky and is set only by a trigger event on a pin whose enable bit is 1 in that cycle. Events on disabled pins are discarded and do not appear when the pin is enabled later.
- R6: Writing 1 to bit p of acknowledge word b clears pending for (b,p). Writing 0 has no effect. If a trigger event and an acknowledge hit the same pin in one cycle, pending ends up set.
- R7: Identity word b reads pending AND enable for bit index b. Writes to identity addresses change nothing.
- R8: Bit 0 of the config word is the global interrupt enable. `irq` equals (OR of all identity bits) AND global enable, delayed by one register stage.
- R9: After reset every enable, trigger, polarity, pending and config bit is 0, and `irq` is 0.
- R10: `scan_ready` is always 1. Pending can change from 0 to 1 only in a cycle where `scan_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_valid | input | 1 | Snapshot present on scan_data |
| scan_ready | output | 1 | Always 1; snapshots are never stalled |
| scan_data | input | NBITS*NPORTS | Pin values, pin (b,p) at bit b*NPORTS+p |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write word address |
| wr_data | input | NPORTS | Register write data |
| rd_addr | input | 6 | Register read word address |
| rd_data | output | NPORTS | Register read data (combinational) |
| irq | output | 1 | Combined registered interrupt |

## Verification
Two situations are hard to reach from the ports. The first is an acknowledge landing in the same cycle as a snapshot that re-triggers the same pin. The bench drives a write strobe and `scan_valid` together in one cycle, on a level-high pin that holds its active value, and then reads the identity word.

The second is the first snapshot after reset. There a rising-edge pin already at 1 must stay quiet. The bench reaches it with a fresh reset directly before the snapshot.

Every trigger type is also walked through a table of previous and current pin values. The acknowledge in the middle of each entry isolates the effect of the second snapshot.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned MAX_BITS = 4;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_BOTH  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RISE  = 2'd3
  } trig_e;

  // register group = address[5:2], word index = address[1:0]
  localparam logic [3:0] G_CFG = 4'h0;
  localparam logic [3:0] G_EN  = 4'h1;
  localparam logic [3:0] G_TLO = 4'h2;
  localparam logic [3:0] G_THI = 4'h3;
  localparam logic [3:0] G_POL = 4'h4;
  localparam logic [3:0] G_ACK = 4'h5;
  localparam logic [3:0] G_IDN = 4'h6;
endpackage

// File: rtl/sgi_regs.sv
module sgi_regs
  import sgi_pkg::*;
#(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned NBITS  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [NPORTS-1:0]             wr_data,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic [NBITS-1:0][NPORTS-1:0]  ident,
  output logic [NBITS-1:0][NPORTS-1:0]  en,
  output logic [NBITS-1:0][NPORTS-1:0]  tlo,
  output logic [NBITS-1:0][NPORTS-1:0]  thi,
  output logic [NBITS-1:0][NPORTS-1:0]  pol,
  output logic [NBITS-1:0][NPORTS-1:0]  ack,
  output logic                          master,
  output logic [NPORTS-1:0]             rd_data
);
  logic [3:0] wgrp, rgrp;
  logic [1:0] widx, ridx;
  logic       widx_ok, ridx_ok;

  assign wgrp    = wr_addr[5:2];
  assign widx    = wr_addr[1:0];
  assign rgrp    = rd_addr[5:2];
  assign ridx    = rd_addr[1:0];
  assign widx_ok = (32'(widx) < NBITS);
  assign ridx_ok = (32'(ridx) < NBITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      master <= 1'b0;
      en     <= '0;
      tlo    <= '0;
      thi    <= '0;
      pol    <= '0;
    end else if (wr_en && widx_ok) begin
      case (wgrp)
        G_CFG: if (widx == 2'd0) master <= wr_data[0];
        G_EN:  en[widx]  <= wr_data;
        G_TLO: tlo[widx] <= wr_data;
        G_THI: thi[widx] <= wr_data;
        G_POL: pol[widx] <= wr_data;
        default: ;
      endcase
    end
  end

  // acknowledge is a write-only pulse, one word per bit index
  for (genvar b = 0; b < NBITS; b++) begin : g_ack
    assign ack[b] = (wr_en && wgrp == G_ACK && 32'(widx) == b) ? wr_data : '0;
  end

  always_comb begin
    rd_data = '0;
    if (ridx_ok) begin
      case (rgrp)
        G_CFG: if (ridx == 2'd0) rd_data[0] = master;
        G_EN:  rd_data = en[ridx];
        G_TLO: rd_data = tlo[ridx];
        G_THI: rd_data = thi[ridx];
        G_POL: rd_data = pol[ridx];
        G_IDN: rd_data = ident[ridx];
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/sgi_detect.sv
module sgi_detect
  import sgi_pkg::*;
#(
  parameter int unsigned NPORTS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              primed,
  input  logic [NPORTS-1:0] cur,
  input  logic [NPORTS-1:0] en,
  input  logic [NPORTS-1:0] tlo,
  input  logic [NPORTS-1:0] thi,
  input  logic [NPORTS-1:0] pol,
  input  logic [NPORTS-1:0] ack,
  output logic [NPORTS-1:0] pend
);
  logic [NPORTS-1:0] prev, raw, hit;

  for (genvar p = 0; p < NPORTS; p++) begin : g_pin
    always_comb begin
      case (trig_e'({thi[p], tlo[p]}))
        TRIG_LEVEL: raw[p] = cur[p] ^ pol[p];
        TRIG_BOTH:  raw[p] = primed & (cur[p] ^ prev[p]);
        TRIG_FALL:  raw[p] = primed & prev[p] & ~cur[p];
        default:    raw[p] = primed & ~prev[p] & cur[p];
      endcase
    end
  end

  assign hit = fire ? (raw & en) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
    end else begin
      if (fire) prev <= cur;
      pend <= (pend & ~ack) | hit;
    end
  end

  assert_set_on_scan_R10: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend)) != '0) |-> $past(fire));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (!fire && ack != '0) |=> ((pend & $past(ack)) == '0));

  assert_no_set_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~$past(en)) == '0));
endmodule

// File: rtl/sgi_irq_out.sv
module sgi_irq_out #(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned NBITS  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NBITS-1:0][NPORTS-1:0] ident,
  input  logic                         master,
  output logic                         irq
);
  logic any;
  assign any = |ident;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= any & master;
  end

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(master));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(any));
endmodule

// File: rtl/sgi_ctrl.sv
module sgi_ctrl
  import sgi_pkg::*;
#(
  parameter int unsigned NPORTS = 32,
  parameter int unsigned NBITS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scan_valid,
  output logic                    scan_ready,
  input  logic [NBITS*NPORTS-1:0] scan_data,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [NPORTS-1:0]       wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [NPORTS-1:0]       rd_data,
  output logic                    irq
);
  logic [NBITS-1:0][NPORTS-1:0] en, tlo, thi, pol, ack, pend, ident;
  logic master, fire, primed;

  assign scan_ready = 1'b1;
  assign fire       = scan_valid;

  // edges are meaningful only once one snapshot has been taken
  always_ff @(posedge clk) begin
    if (rst)       primed <= 1'b0;
    else if (fire) primed <= 1'b1;
  end

  sgi_regs #(.NPORTS(NPORTS), .NBITS(NBITS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ident(ident), .en(en), .tlo(tlo), .thi(thi), .pol(pol),
    .ack(ack), .master(master), .rd_data(rd_data)
  );

  for (genvar b = 0; b < NBITS; b++) begin : g_word
    sgi_detect #(.NPORTS(NPORTS)) u_det (
      .clk(clk), .rst(rst), .fire(fire), .primed(primed),
      .cur(scan_data[b*NPORTS +: NPORTS]), .en(en[b]), .tlo(tlo[b]),
      .thi(thi[b]), .pol(pol[b]), .ack(ack[b]), .pend(pend[b])
    );
    assign ident[b] = pend[b] & en[b];
  end

  sgi_irq_out #(.NPORTS(NPORTS), .NBITS(NBITS)) u_irq (
    .clk(clk), .rst(rst), .ident(ident), .master(master), .irq(irq)
  );

  initial begin
    assert_params_R1: assert (NBITS >= 1 && NBITS <= MAX_BITS && NPORTS >= 1 && NPORTS <= 32);
  end
endmodule

// File: tb/tb_sgi_ctrl.sv
`timescale 1ns/1ps
module tb_sgi_ctrl;
  localparam int NP = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_valid = 1'b0;
  logic scan_ready;
  logic [NB*NP-1:0] scan_data = '0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [NP-1:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [NP-1:0] rd_data;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sgi_ctrl #(.NPORTS(NP), .NBITS(NB)) dut (
    .clk(clk), .rst(rst), .scan_valid(scan_valid), .scan_ready(scan_ready),
    .scan_data(scan_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // {type[1:0], polarity, previous value, current value, expected pending}
  localparam logic [5:0] VEC [12] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic scan(input logic [NB*NP-1:0] d);
    @(negedge clk);
    scan_valid = 1'b1; scan_data = d;
    @(negedge clk);
    scan_valid = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [NP-1:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] v;
    do_reset();

    // R9: reset state
    for (int b = 0; b < NB; b++) begin
      rd(6'h04 + 6'(b), v); check("R9 enable reset", v, '0);
      rd(6'h08 + 6'(b), v); check("R9 trig-low reset", v, '0);
      rd(6'h18 + 6'(b), v); check("R9 identity reset", v, '0);
    end
    rd(6'h00, v); check("R9 config reset", v, '0);
    check("R9 irq reset", {31'd0, irq}, '0);
    check("R10 scan_ready high", {31'd0, scan_ready}, 32'd1);

    // R2 R3 R4: table walk, one pin per entry
    scan('0);
    for (int i = 0; i < 12; i++) begin
      int b, p;
      logic [NB*NP-1:0] d0, d1;
      b = i % NB;
      p = (i * 7) % NP;
      for (int k = 0; k < NB; k++) wr(6'h04 + 6'(k), '0);
      wr(6'h08 + 6'(b), VEC[i][4] ? (32'd1 << p) : '0);
      wr(6'h0C + 6'(b), VEC[i][5] ? (32'd1 << p) : '0);
      wr(6'h10 + 6'(b), VEC[i][3] ? (32'd1 << p) : '0);
      wr(6'h04 + 6'(b), 32'd1 << p);
      d0 = '0; d0[b*NP+p] = VEC[i][2];
      d1 = '0; d1[b*NP+p] = VEC[i][1];
      scan(d0);
      wr(6'h14 + 6'(b), '1);
      scan(d1);
      rd(6'h18 + 6'(b), v);
      check($sformatf("R2 R3 R4 vector %0d", i), v, VEC[i][0] ? (32'd1 << p) : '0);
    end

    // R4: first snapshot after reset yields no edge
    do_reset();
    wr(6'h08, 32'd1);
    wr(6'h0C, 32'd1);
    wr(6'h04, 32'd1);
    scan({{(NB*NP-1){1'b0}}, 1'b1});
    rd(6'h18, v); check("R4 no edge on first snapshot", v, '0);
    scan('0);
    scan({{(NB*NP-1){1'b0}}, 1'b1});
    rd(6'h18, v); check("R4 rising edge after priming", v, 32'd1);

    // R8: global enable gates irq, one register stage
    @(negedge clk);
    check("R8 irq masked by global enable", {31'd0, irq}, '0);
    wr(6'h00, 32'd1);
    check("R8 irq one stage after enable", {31'd0, irq}, '0);
    @(negedge clk);
    check("R8 irq asserted", {31'd0, irq}, 32'd1);
    rd(6'h00, v); check("R1 config readback", v, 32'd1);

    // R6: acknowledge clears pending, irq follows one cycle later
    wr(6'h14, 32'd0);
    rd(6'h18, v); check("R6 zero ack no effect", v, 32'd1);
    wr(6'h14, 32'd1);
    rd(6'h18, v); check("R6 ack clears pending", v, '0);
    rd(6'h14, v); check("R1 ack reads zero", v, '0);
    @(negedge clk);
    check("R8 irq drops after ack", {31'd0, irq}, '0);

    // R6: event and acknowledge in the same cycle, event wins
    wr(6'h09, '0);
    wr(6'h0D, '0);
    wr(6'h11, '0);
    wr(6'h05, 32'd1 << 3);
    @(negedge clk);
    scan_valid = 1'b1; scan_data = '0; scan_data[1*NP+3] = 1'b1;
    wr_en = 1'b1; wr_addr = 6'h15; wr_data = 32'd1 << 3;
    @(negedge clk);
    scan_valid = 1'b0; wr_en = 1'b0;
    rd(6'h19, v); check("R6 event beats ack", v, 32'd1 << 3);

    // R5: events on a disabled pin are discarded
    wr(6'h0A, 32'd1 << 5);
    wr(6'h0E, 32'd1 << 5);
    wr(6'h06, '0);
    scan('0);
    begin
      logic [NB*NP-1:0] d;
      d = '0; d[2*NP+5] = 1'b1;
      scan(d);
    end
    wr(6'h06, 32'd1 << 5);
    rd(6'h1A, v); check("R5 disabled pin ignored", v, '0);
    rd(6'h0A, v); check("R1 trig-low readback", v, 32'd1 << 5);

    // R7: identity is read-only
    wr(6'h1A, '1);
    rd(6'h1A, v); check("R7 identity write ignored", v, '0);
    rd(6'h06, v); check("R7 enable untouched", v, 32'd1 << 5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule